// File: doc/BRIEF.md
# Critical Fault Response Controller

This block decides how a power-management subsystem reacts to a critical fault. Four kinds of condition count as critical: an undervoltage or overvoltage on any monitored rail, an overcurrent, a failure reported by the power sequencer, and an external fault line pulled low by another device. When one appears, the block commands the sequencer to shut the rails down. It then either holds the system off, or restarts it on its own after a programmed wait.

A 2-bit response selector picks the behaviour. In latch mode the system stays off until one of the two enable sources, the hardware enable pin or the software enable bit, makes a low-to-high transition while no critical condition is present. In autoretry mode the block waits for a 3-bit delay code's interval of fault-free time, then releases the shutdown and pulses a restart strobe to the sequencer.

The block also drives an active-low summary fault output and a cascade output on the external fault line. It keeps a sticky record of which sources have tripped, and software clears that record with a strobe.

Top module: `fault_response_ctrl`

## Requirements
- R1: After reset, with both enables high and no fault present, `seq_shutdown` is 0, `seq_restart` is 0, `any_fault_n` is 1, `ext_out_n` is 1 and `cause_flags` is all zeros.
- R2: Every critical source forces `seq_shutdown` to 1 at the first clock edge that sees it. The cause bit order is rails at [N_RAILS-1:0], overcurrent at N_RAILS, sequencer failure at N_RAILS+1 and external fault at N_RAILS+2. The external line counts only when `ext_is_out` is 0 and `ext_in_n` is 0.
- R3: With `resp_mode` = 00 (latch), the shutdown persists after the fault disappears. It is released at the first clock edge that sees a rising edge of `hw_en` or `sw_en` while no critical source is active.
- R4: In latch mode, an enable rising edge that occurs while a critical source is still active does not release the shutdown.
- R5: With `resp_mode` other than 00 (autoretry), `seq_shutdown` returns to 0 at exactly the D-th clock edge after the last edge that saw a fault, where D = ms × TICKS_PER_MS. Codes 0..7 of `retry_code` select ms = 20, 40, 80, 160, 320, 640, 1280 and 2000.
- R6: A critical source that reappears during the autoretry wait restarts the full delay, counted from the last edge that saw it.
- R7: `seq_restart` is high for exactly one cycle, in the first cycle after the shutdown is released.
- R8: `any_fault_n` goes to 0 one clock after any critical source or either bit of `grp_flt` is high, and stays 0 while the shutdown is held. `grp_flt` alone does not cause a shutdown.
- R9: When `ext_is_out` is 1, `ext_out_n` is 0 exactly while a fault shutdown is held, and `ext_in_n` has no effect. When `ext_is_out` is 0, `ext_out_n` stays 1.
- R10: A `cause_flags` bit is set one clock after its source is active and stays set until a `flag_clr` strobe. On a clear strobe the register takes only the causes active in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rail_flt | input | N_RAILS | Per-rail UV/OV fault, active high |
| ocp_flt | input | 1 | Overcurrent fault |
| seq_flt | input | 1 | Sequencer failure |
| ext_in_n | input | 1 | External fault line as read, active low |
| ext_is_out | input | 1 | 1 = external line is a cascade output |
| grp_flt | input | 2 | Grouped fault outputs, feed the summary only |
| resp_mode | input | 2 | 00 = latch, else autoretry |
| retry_code | input | 3 | Autoretry delay code |
| hw_en | input | 1 | Hardware enable |
| sw_en | input | 1 | Software enable bit |
| flag_clr | input | 1 | Clear strobe for the cause record |
| seq_shutdown | output | 1 | Shutdown command to the sequencer |
| seq_restart | output | 1 | One-cycle restart strobe |
| any_fault_n | output | 1 | Active-low summary fault |
| ext_out_n | output | 1 | Cascade drive for the external line, active low |
| cause_flags | output | N_RAILS+3 | Sticky cause record |

## Verification
The embedded properties check, on every cycle, the following:
- a fault in run state always leaves run;
- a held latch never leaves without an enable rising edge;
- a wait never ends while a fault is present;
- the restart strobe never lasts two cycles;
- a timer load never reports expiry on the next cycle;
- recorded causes never drop without a clear.

Only the bench scenarios can show the exact delay length for each code, that the interval restarts on a fault pulse, that an enable toggle during a fault is refused, and that the cascade line is ignored in output mode.

// File: rtl/cfr_pkg.sv
package cfr_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_LATCH = 2'd1,
        ST_RETRY = 2'd2
    } cfr_state_e;

    localparam logic [1:0] MODE_LATCH = 2'b00;
    localparam int unsigned MAX_RETRY_MS = 2000;

    // Autoretry interval in milliseconds for a 3-bit code.
    function automatic int unsigned retry_ms(input logic [2:0] code);
        int unsigned ms;
        case (code)
            3'd7:    ms = MAX_RETRY_MS;
            default: ms = 32'd20 << code;
        endcase
        return ms;
    endfunction

endpackage

// File: rtl/cfr_fault_merge.sv
module cfr_fault_merge #(
    parameter int N_RAILS = 8,
    localparam int NC = N_RAILS + 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_RAILS-1:0] rail_flt,
    input  logic               ocp_flt,
    input  logic               seq_flt,
    input  logic               ext_in_n,
    input  logic               ext_is_out,
    input  logic               flag_clr,
    output logic               crit_now,
    output logic [NC-1:0]      flags
);
    logic [NC-1:0] cause;

    for (genvar i = 0; i < N_RAILS; i++) begin : g_rail
        assign cause[i] = rail_flt[i];
    end
    assign cause[N_RAILS]     = ocp_flt;
    assign cause[N_RAILS + 1] = seq_flt;
    assign cause[N_RAILS + 2] = ~ext_is_out & ~ext_in_n;

    assign crit_now = |cause;

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flag_clr ? '0 : flags) | cause;
    end

    assert_flags_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        !flag_clr |=> ((flags & $past(flags)) == $past(flags)));

endmodule

// File: rtl/cfr_retry_timer.sv
module cfr_retry_timer #(
    parameter int TICKS_PER_MS = 1000,
    localparam int CNT_W = $clog2(cfr_pkg::MAX_RETRY_MS * TICKS_PER_MS + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [2:0] code,
    output logic       expired
);
    import cfr_pkg::*;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= CNT_W'(retry_ms(code) * TICKS_PER_MS - 1);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    assert_load_not_expired_R5: assert property (@(posedge clk) disable iff (rst)
        load |=> !expired);

endmodule

// File: rtl/cfr_ctrl_fsm.sv
module cfr_ctrl_fsm (
    input  logic                clk,
    input  logic                rst,
    input  logic                crit_now,
    input  logic                grp_any,
    input  logic [1:0]          mode,
    input  logic                hw_en,
    input  logic                sw_en,
    input  logic                expired,
    output cfr_pkg::cfr_state_e state,
    output logic                load,
    output logic                restart,
    output logic                any_fault_n
);
    import cfr_pkg::*;

    cfr_state_e nxt;
    logic       hw_q, sw_q, en_rise;

    assign en_rise = (hw_en & ~hw_q) | (sw_en & ~sw_q);
    assign load    = (state != ST_RETRY) | crit_now;

    always_comb begin
        nxt = state;
        case (state)
            ST_RUN:   if (crit_now) nxt = (mode == MODE_LATCH) ? ST_LATCH : ST_RETRY;
            ST_LATCH: if (en_rise && !crit_now) nxt = ST_RUN;
            ST_RETRY: if (expired && !crit_now) nxt = ST_RUN;
            default:  nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_RUN;
            hw_q        <= 1'b0;
            sw_q        <= 1'b0;
            restart     <= 1'b0;
            any_fault_n <= 1'b1;
        end else begin
            state       <= nxt;
            hw_q        <= hw_en;
            sw_q        <= sw_en;
            restart     <= (state != ST_RUN) && (nxt == ST_RUN);
            any_fault_n <= ~(crit_now | grp_any | (state != ST_RUN));
        end
    end

    assert_fault_leaves_run_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && crit_now) |=> (state != ST_RUN));
    assert_latch_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LATCH && !en_rise) |=> (state == ST_LATCH));
    assert_latch_fault_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LATCH && crit_now) |=> (state == ST_LATCH));
    assert_wait_fault_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RETRY && crit_now) |=> (state == ST_RETRY));
    assert_restart_single_R7: assert property (@(posedge clk) disable iff (rst)
        restart |=> !restart);

endmodule

// File: rtl/fault_response_ctrl.sv
module fault_response_ctrl #(
    parameter int N_RAILS      = 8,
    parameter int TICKS_PER_MS = 1000,
    localparam int NC = N_RAILS + 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_RAILS-1:0] rail_flt,
    input  logic               ocp_flt,
    input  logic               seq_flt,
    input  logic               ext_in_n,
    input  logic               ext_is_out,
    input  logic [1:0]         grp_flt,
    input  logic [1:0]         resp_mode,
    input  logic [2:0]         retry_code,
    input  logic               hw_en,
    input  logic               sw_en,
    input  logic               flag_clr,
    output logic               seq_shutdown,
    output logic               seq_restart,
    output logic               any_fault_n,
    output logic               ext_out_n,
    output logic [NC-1:0]      cause_flags
);
    import cfr_pkg::*;

    logic       crit_now, load, expired, held;
    cfr_state_e state;

    cfr_fault_merge #(.N_RAILS(N_RAILS)) u_merge (
        .clk(clk), .rst(rst), .rail_flt(rail_flt), .ocp_flt(ocp_flt),
        .seq_flt(seq_flt), .ext_in_n(ext_in_n), .ext_is_out(ext_is_out),
        .flag_clr(flag_clr), .crit_now(crit_now), .flags(cause_flags)
    );

    cfr_retry_timer #(.TICKS_PER_MS(TICKS_PER_MS)) u_timer (
        .clk(clk), .rst(rst), .load(load), .code(retry_code), .expired(expired)
    );

    cfr_ctrl_fsm u_fsm (
        .clk(clk), .rst(rst), .crit_now(crit_now), .grp_any(|grp_flt),
        .mode(resp_mode), .hw_en(hw_en), .sw_en(sw_en), .expired(expired),
        .state(state), .load(load), .restart(seq_restart),
        .any_fault_n(any_fault_n)
    );

    assign held         = (state != ST_RUN);
    assign seq_shutdown = held | ~(hw_en & sw_en);
    assign ext_out_n    = ~(ext_is_out & held);

    assert_summary_while_held_R8: assert property (@(posedge clk) disable iff (rst)
        (held && $past(held)) |-> !any_fault_n);
    assert_cascade_R9: assert property (@(posedge clk) disable iff (rst)
        !ext_is_out |-> ext_out_n);

endmodule

// File: tb/tb_fault_response_ctrl.sv
module tb_fault_response_ctrl;
    localparam int NR  = 4;
    localparam int TPM = 2;
    localparam int NC  = NR + 3;

    logic clk = 0, rst = 1;
    logic [NR-1:0] rail_flt = '0;
    logic ocp_flt = 0, seq_flt = 0, ext_in_n = 1, ext_is_out = 0;
    logic [1:0] grp_flt = '0, resp_mode = '0;
    logic [2:0] retry_code = '0;
    logic hw_en = 1, sw_en = 1, flag_clr = 0;
    logic seq_shutdown, seq_restart, any_fault_n, ext_out_n;
    logic [NC-1:0] cause_flags;

    int total = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    fault_response_ctrl #(.N_RAILS(NR), .TICKS_PER_MS(TPM)) dut (
        .clk(clk), .rst(rst), .rail_flt(rail_flt), .ocp_flt(ocp_flt),
        .seq_flt(seq_flt), .ext_in_n(ext_in_n), .ext_is_out(ext_is_out),
        .grp_flt(grp_flt), .resp_mode(resp_mode), .retry_code(retry_code),
        .hw_en(hw_en), .sw_en(sw_en), .flag_clr(flag_clr),
        .seq_shutdown(seq_shutdown), .seq_restart(seq_restart),
        .any_fault_n(any_fault_n), .ext_out_n(ext_out_n),
        .cause_flags(cause_flags)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic set_src(input int idx, input logic v);
        if (idx < NR)           rail_flt[idx] = v;
        else if (idx == NR)     ocp_flt = v;
        else if (idx == NR + 1) seq_flt = v;
        else                    ext_in_n = ~v;
    endtask

    task automatic measure(output int n);
        n = 0;
        while (seq_shutdown && n < 5000) begin
            step();
            n++;
        end
    endtask

    task automatic clear_flags();
        flag_clr = 1; step(); flag_clr = 0;
    endtask

    function automatic int exp_delay(input int code);
        return (code == 7 ? 2000 : (20 << code)) * TPM;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        @(negedge clk); step(); step(); rst = 0; step();
        // R1 reset state
        check("R1 shutdown", 32'(seq_shutdown), 0);
        check("R1 restart", 32'(seq_restart), 0);
        check("R1 any_fault_n", 32'(any_fault_n), 1);
        check("R1 ext_out_n", 32'(ext_out_n), 1);
        check("R1 flags", 32'(cause_flags), 0);

        // Autoretry sweep: every mode != 00, every code, rotating source
        for (int m = 1; m < 4; m++) begin
            for (int c = 0; c < 8; c++) begin
                int src = (m * 8 + c) % NC;
                resp_mode = 2'(m); retry_code = 3'(c);
                set_src(src, 1); step();
                check("R2 shutdown on source", 32'(seq_shutdown), 1);
                check("R8 any_fault_n low", 32'(any_fault_n), 0);
                check("R10 flag set", 32'(cause_flags), 32'(1 << src));
                step(); step();
                set_src(src, 0);
                measure(n);
                check("R5 retry delay", 32'(n), 32'(exp_delay(c)));
                check("R7 restart high", 32'(seq_restart), 1);
                step();
                check("R7 restart one cycle", 32'(seq_restart), 0);
                check("R8 any_fault_n back", 32'(any_fault_n), 1);
                check("R10 flag sticky", 32'(cause_flags), 32'(1 << src));
                clear_flags();
                check("R10 cleared", 32'(cause_flags), 0);
            end
        end

        // R6 fault re-appearing mid-wait restarts the delay
        resp_mode = 2'b01; retry_code = 3'd0;
        ocp_flt = 1; step(); ocp_flt = 0;
        repeat (25) step();
        check("R6 still waiting", 32'(seq_shutdown), 1);
        seq_flt = 1; step(); seq_flt = 0;
        measure(n);
        check("R6 delay restarted", 32'(n), 32'(exp_delay(0)));
        step(); clear_flags();

        // R10 clear strobe with a cause active: new cause kept
        rail_flt[1] = 1; step();
        flag_clr = 1; rail_flt[1] = 0; rail_flt[2] = 1; step();
        flag_clr = 0; rail_flt[2] = 0;
        check("R10 clear keeps new cause", 32'(cause_flags), 32'(4));
        measure(n); step(); clear_flags();

        // R3/R4 latch mode
        resp_mode = 2'b00;
        rail_flt[0] = 1; step();
        check("R3 latched shutdown", 32'(seq_shutdown), 1);
        sw_en = 0; step(); sw_en = 1; step();
        check("R4 toggle during fault refused", 32'(seq_shutdown), 1);
        rail_flt[0] = 0; repeat (100) step();
        check("R3 held after fault gone", 32'(seq_shutdown), 1);
        check("R8 any_fault_n while held", 32'(any_fault_n), 0);
        hw_en = 0; step();
        check("R3 off while enable low", 32'(seq_shutdown), 1);
        hw_en = 1; step();
        check("R3 released by enable edge", 32'(seq_shutdown), 0);
        check("R7 restart after latch", 32'(seq_restart), 1);
        step(); clear_flags();

        // R8 grouped faults: summary only
        grp_flt = 2'b10; step();
        check("R8 grp any_fault_n", 32'(any_fault_n), 0);
        check("R8 grp no shutdown", 32'(seq_shutdown), 0);
        grp_flt = 2'b00; step();
        check("R8 grp released", 32'(any_fault_n), 1);

        // R9 cascade output mode
        ext_is_out = 1; ext_in_n = 0; step(); step();
        check("R9 input ignored", 32'(seq_shutdown), 0);
        check("R9 input ignored flags", 32'(cause_flags), 0);
        check("R9 out idle", 32'(ext_out_n), 1);
        ocp_flt = 1; step(); ocp_flt = 0;
        check("R9 out driven", 32'(ext_out_n), 0);
        sw_en = 0; step(); sw_en = 1; step();
        check("R9 out released", 32'(ext_out_n), 1);
        ext_in_n = 1; ext_is_out = 0;
        seq_flt = 1; step(); seq_flt = 0;
        check("R9 input mode no drive", 32'(ext_out_n), 1);
        step();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule